// File: doc/BRIEF.md
# Serial Tag Memory Host Controller

This block sits on the host side of a four-wire serial link (active-low select, serial clock, host-to-flash data, flash-to-host data) to a flash tag memory. A one-cycle `start` with an operation code runs one of three jobs. A tag readout shifts out a command byte, clocks through the flash's dummy period, waits if the serial clock is too fast for the flash's internal transfer, and then collects exactly `TAG_BITS` bits into a parallel word. A write-enable sends one command byte. A status poll first issues write-enable and then repeats a one-bit status read until the flash reports completion or the poll budget runs out.

The tag word leaves through a valid/ready port. `tag_valid` rises once the last bit is in and select is released. `tag_data` stays frozen while `tag_ready` is low. The job only ends (`done`) on the cycle after the word is accepted, so a slow consumer stalls the controller and loses no data. `busy`, `done` and `fail` are plain status pins.

Top module: `tag_host_ctrl`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `fail` and `tag_valid` are 0.
- R2: Command bytes go out on `si` most significant bit first. `si` changes only while `sclk` is low, and `sclk` stays low whenever `cs_n` is high.
- R3: When the controller is idle, `start` selects the job from `op`: 2'b00 is tag readout (opcode `OP_TAG`), 2'b01 is write-enable alone (opcode `OP_WREN`), and 2'b10 is status poll. A `start` with `op` = 2'b11, or any `start` while `busy` is 1, causes no transaction.
- R4: A tag readout is one select-low window of exactly 8 + 24 + `TAG_BITS` rising serial clock edges: 8 command, 24 dummy and `TAG_BITS` data. The controller never over-shifts.
- R5: Data is sampled on rising `sclk` edges. The first sample is taken on the edge after the 24th dummy edge and becomes `tag_data[TAG_BITS-1]`. Later samples fill the lower bits in turn, down to bit 0.
- R6: At least `XFER_MIN_CYC` system clocks pass between the last falling edge of the command and the first data sample. If the dummy clocks alone are shorter than this, the controller holds `sclk` low with select asserted for the remainder.
- R7: Every high phase of `sclk` lasts `HALF_DIV` system clocks. With a 250 MHz system clock, the default of 50 gives 2.5 MHz.
- R8: `tag_valid` stays 1 and `tag_data` stays stable until `tag_ready` is 1. The word is accepted on the first clock with both signals high.
- R9: A status poll first sends `OP_WREN` in its own select window. Every status read is then opcode 0x4A followed by one extra clock, and the status bit is sampled on the 9th rising edge.
- R10: Between two status reads, `cs_n` stays high with `sclk` low for at least `POLL_GAP_CYC` system clocks.
- R11: The poll ends without failure on the first status bit of 1. If `POLL_MAX` reads all return 0, the poll ends with `fail` at 1. `fail` then holds until the next accepted `start` clears it.
- R12: `busy` is 1 from the cycle after an accepted `start` through the cycle in which `done` is high. `done` is high for exactly one cycle.
- R13: Any two select-low windows are separated by at least `DESEL_CYC` system clocks with `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job request, taken only when idle |
| op | input | 2 | Job code, see R3 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fail | output | 1 | Last status poll ran out of reads |
| tag_valid | output | 1 | Tag word available |
| tag_ready | input | 1 | Consumer accepts tag word |
| tag_data | output | TAG_BITS | Assembled tag word, first bit at the top |
| cs_n | output | 1 | Flash select, active low |
| sclk | output | 1 | Serial clock, idles low |
| si | output | 1 | Host-to-flash serial data |
| so | input | 1 | Flash-to-host serial data |

## Verification
A corrupted clock-count register shows up at the select release as an edge total that differs from 8+24+`TAG_BITS`, 8 or 9. A corrupted bit order shows up as a mismatched `tag_data` on the first `tag_valid`. A wrong wait or divider counter shows up within one serial period as a short `sclk` high phase, or as a data sample that arrives earlier than the transfer delay allows. A broken poll counter shows up at `done` as the wrong number of status windows or the wrong `fail` level. A damaged handshake shows up as `done` firing while `tag_ready` is still low.

// File: rtl/tag_host_pkg.sv
package tag_host_pkg;

  typedef enum logic [1:0] {
    REQ_READ  = 2'b00,
    REQ_WREN  = 2'b01,
    REQ_POLL  = 2'b10,
    REQ_NONE  = 2'b11
  } req_e;

  typedef enum logic [1:0] {
    K_TAG,
    K_WREN,
    K_STAT
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_CMD,
    S_DUMMY,
    S_XWAIT,
    S_DATA,
    S_SBIT,
    S_HOLD,
    S_FIN
  } st_e;

  localparam int CMD_CLKS   = 8;
  localparam int DUMMY_CLKS = 24;
  localparam logic [7:0] STATUS_OPCODE = 8'h4A;

endpackage

// File: rtl/tag_sclk_engine.sv
module tag_sclk_engine #(
  parameter int HALF_DIV = 50,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] nclk,
  input  logic [7:0]    tx,
  input  logic          so,
  output logic          sclk,
  output logic          si,
  output logic          smp_valid,
  output logic          smp_bit,
  output logic          fin
);

  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          run;
  logic [PW-1:0] ph;
  logic [CW-1:0] left;
  logic [7:0]    shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      ph        <= '0;
      left      <= '0;
      shreg     <= '0;
      sclk      <= 1'b0;
      smp_valid <= 1'b0;
      smp_bit   <= 1'b0;
      fin       <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      fin       <= 1'b0;
      if (go) begin
        run   <= 1'b1;
        ph    <= '0;
        sclk  <= 1'b0;
        shreg <= tx;
        left  <= nclk;
      end else if (run) begin
        if (ph == PW'(HALF_DIV - 1)) begin
          ph <= '0;
          if (!sclk) begin
            sclk      <= 1'b1;
            smp_valid <= 1'b1;
            smp_bit   <= so;
          end else begin
            sclk  <= 1'b0;
            shreg <= {shreg[6:0], 1'b0};
            left  <= left - 1'b1;
            if (left == CW'(1)) begin
              run <= 1'b0;
              fin <= 1'b1;
            end
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign si = shreg[7];

  AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run); // R4
  AST_SI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(si)); // R2

endmodule

// File: rtl/tag_shift_in.sv
module tag_shift_in #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (en) word <= {word[WIDTH-2:0], bit_in};
  end

endmodule

// File: rtl/tag_host_ctrl.sv
module tag_host_ctrl
  import tag_host_pkg::*;
#(
  parameter int         TAG_BITS     = 32,
  parameter int         HALF_DIV     = 50,
  parameter int         XFER_MIN_CYC = 1250,
  parameter int         DESEL_CYC    = 4,
  parameter int         POLL_GAP_CYC = 16,
  parameter int         POLL_MAX     = 1000,
  parameter logic [7:0] OP_TAG       = 8'hE2,
  parameter logic [7:0] OP_WREN      = 8'h3C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic                tag_valid,
  input  logic                tag_ready,
  output logic [TAG_BITS-1:0] tag_data,
  output logic                cs_n,
  output logic                sclk,
  output logic                si,
  input  logic                so
);

  localparam int MAXC      = (TAG_BITS > DUMMY_CLKS) ? TAG_BITS : DUMMY_CLKS;
  localparam int CW        = $clog2(MAXC + 1);
  localparam int DUMMY_SYS = DUMMY_CLKS * 2 * HALF_DIV;
  localparam int WAIT_CYC  = (XFER_MIN_CYC > DUMMY_SYS) ? (XFER_MIN_CYC - DUMMY_SYS) : 0;
  localparam int WW        = $clog2(WAIT_CYC + 2);
  localparam int GMAX      = (DESEL_CYC > POLL_GAP_CYC) ? DESEL_CYC : POLL_GAP_CYC;
  localparam int GW        = $clog2(GMAX + 2) + 1;
  localparam int PCW       = $clog2(POLL_MAX + 1);
  localparam int XW        = $clog2(XFER_MIN_CYC + 2) + 1;

  st_e           st;
  req_e          req;
  kind_e         kind;
  logic          go, go_cmd;
  logic [CW-1:0] nclk;
  logic [7:0]    cmd_byte;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] idle_cnt, need;
  logic [PCW-1:0] poll_cnt;
  logic          retry, stat_bit, wren_sent, fail_q;
  logic          smp_valid, smp_bit, fin;
  logic [XW-1:0] xcnt;

  always_comb begin
    case (kind)
      K_TAG:   cmd_byte = OP_TAG;
      K_WREN:  cmd_byte = OP_WREN;
      default: cmd_byte = STATUS_OPCODE;
    endcase
  end

  assign need = retry ? GW'(POLL_GAP_CYC) : GW'(DESEL_CYC);

  tag_sclk_engine #(.HALF_DIV(HALF_DIV), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .nclk(nclk),
    .tx(go_cmd ? cmd_byte : 8'h00), .so(so),
    .sclk(sclk), .si(si), .smp_valid(smp_valid), .smp_bit(smp_bit), .fin(fin)
  );

  tag_shift_in #(.WIDTH(TAG_BITS)) u_collect (
    .clk(clk), .rst_n(rst_n), .en(smp_valid && st == S_DATA),
    .bit_in(smp_bit), .word(tag_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!cs_n) idle_cnt <= '0;
    else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; req <= REQ_NONE; kind <= K_TAG;
      go <= 1'b0; go_cmd <= 1'b0; nclk <= '0; wcnt <= '0;
      poll_cnt <= '0; retry <= 1'b0; stat_bit <= 1'b0;
      wren_sent <= 1'b0; fail_q <= 1'b0; cs_n <= 1'b1;
    end else begin
      go     <= 1'b0;
      go_cmd <= 1'b0;
      case (st)
        S_IDLE: if (start && req_e'(op) != REQ_NONE) begin
          req      <= req_e'(op);
          kind     <= (req_e'(op) == REQ_READ) ? K_TAG : K_WREN;
          fail_q   <= 1'b0;
          retry    <= 1'b0;
          poll_cnt <= '0;
          st       <= S_SETUP;
        end
        S_SETUP: if (idle_cnt >= need) begin
          cs_n <= 1'b0; go <= 1'b1; go_cmd <= 1'b1;
          nclk <= CW'(CMD_CLKS); st <= S_CMD;
        end
        S_CMD: if (fin) begin
          case (kind)
            K_TAG: begin
              go <= 1'b1; nclk <= CW'(DUMMY_CLKS); st <= S_DUMMY;
            end
            K_STAT: begin
              go <= 1'b1; nclk <= CW'(1); st <= S_SBIT;
            end
            default: begin
              wren_sent <= 1'b1;
              cs_n      <= 1'b1;
              if (req == REQ_WREN) st <= S_FIN;
              else begin
                kind <= K_STAT; retry <= 1'b0; st <= S_SETUP;
              end
            end
          endcase
        end
        S_DUMMY: if (fin) begin
          if (WAIT_CYC == 0) begin
            go <= 1'b1; nclk <= CW'(TAG_BITS); st <= S_DATA;
          end else begin
            wcnt <= '0; st <= S_XWAIT;
          end
        end
        S_XWAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WW'(WAIT_CYC - 1)) begin
            go <= 1'b1; nclk <= CW'(TAG_BITS); st <= S_DATA;
          end
        end
        S_DATA: if (fin) begin
          cs_n <= 1'b1; st <= S_HOLD;
        end
        S_SBIT: begin
          if (smp_valid) stat_bit <= smp_bit;
          if (fin) begin
            cs_n <= 1'b1;
            if (stat_bit) st <= S_FIN;
            else if (poll_cnt == PCW'(POLL_MAX - 1)) begin
              fail_q <= 1'b1; st <= S_FIN;
            end else begin
              poll_cnt <= poll_cnt + 1'b1; retry <= 1'b1; st <= S_SETUP;
            end
          end
        end
        S_HOLD: if (tag_ready) st <= S_FIN;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xcnt <= '0;
    else if (st == S_CMD && fin) xcnt <= '0;
    else if (xcnt != '1) xcnt <= xcnt + 1'b1;
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign tag_valid = (st == S_HOLD);
  assign fail      = fail_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2
  AST_DESEL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(idle_cnt) >= GW'(DESEL_CYC)); // R13
  AST_XFER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && st == S_DATA) |-> xcnt >= XW'(XFER_MIN_CYC)); // R6
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=> (tag_valid && $stable(tag_data))); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_STAT_AFTER_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && kind == K_STAT) |-> wren_sent); // R9
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PCW'(POLL_MAX)); // R11
  AST_FAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start && fail) |=> fail); // R11

endmodule

// File: tb/tag_host_ctrl_test.sv
module tag_host_ctrl_test;
  localparam int N = 32, HD = 2, XMIN = 200, DES = 3, PGAP = 6, PMAX = 5;
  localparam logic [7:0] OPT = 8'hE2, OPW = 8'h3C, OPS = 8'h4A;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tag_ready = 1'b0, so_r = 1'b0;
  logic [1:0] op = 2'b00;
  logic busy, done, fail, tag_valid, cs_n, sclk, si;
  logic [N-1:0] tag_data;

  always #2 clk = ~clk;

  tag_host_ctrl #(.TAG_BITS(N), .HALF_DIV(HD), .XFER_MIN_CYC(XMIN), .DESEL_CYC(DES),
    .POLL_GAP_CYC(PGAP), .POLL_MAX(PMAX), .OP_TAG(OPT), .OP_WREN(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy), .done(done),
    .fail(fail), .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_data(tag_data),
    .cs_n(cs_n), .sclk(sclk), .si(si), .so(so_r));

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // flash model
  int rises, falls, poll_idx, ready_k, n_tx, last_rises;
  logic [7:0] cmd, last_cmd;
  logic [N-1:0] tag_mem;
  bit wren_seen, prev_stat;
  time t_csrise, t_cmd_end, t_first, t_rise, gap;

  always @(negedge cs_n) begin
    rises = 0; falls = 0; cmd = 8'h00;
    gap = $time - t_csrise;
    if (n_tx > 1) chk(gap >= DES * 4, "R13", gap / 4, DES);
  end

  always @(posedge sclk) if (!cs_n) begin
    rises++;
    t_rise = $time;
    if (rises <= 8) cmd = {cmd[6:0], si};
    if (cmd == OPT && rises == 32) so_r <= tag_mem[N-1];
    if (cmd == OPT && rises == 33) t_first = $time;
  end

  always @(negedge sclk) if (!cs_n) begin
    falls++;
    chk(($time - t_rise) == HD * 4, "R7", ($time - t_rise) / 4, HD);
    if (falls == 8) t_cmd_end = $time;
    if (cmd == OPT && rises >= 33 && rises < 32 + N) so_r <= tag_mem[N-1-(rises-32)];
    if (cmd == OPS && falls == 8) so_r <= (poll_idx >= ready_k);
  end

  always @(posedge cs_n) begin
    n_tx++;
    last_rises = rises; last_cmd = cmd;
    if (cmd == OPT && rises > 0) begin
      chk(rises == 32 + N, "R4", rises, 32 + N);
      chk((t_first - t_cmd_end) >= XMIN * 4, "R6", (t_first - t_cmd_end) / 4, XMIN);
    end
    if (cmd == OPW && rises > 0) begin
      wren_seen = 1;
      chk(rises == 8, "R3", rises, 8);
    end
    if (cmd == OPS && rises > 0) begin
      chk(wren_seen, "R9", 0, 1);
      chk(rises == 9, "R9", rises, 9);
      if (prev_stat) chk(gap >= PGAP * 4, "R10", gap / 4, PGAP);
      poll_idx++;
      prev_stat = 1;
    end else prev_stat = 0;
    t_csrise = $time;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic kick(input logic [1:0] o);
    @(negedge clk); start = 1; op = o;
    @(negedge clk); start = 0;
    chk(busy == 1, "R12", busy, 1);
  endtask

  task automatic finish_job();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1, "R12", done, 1);
    chk(busy == 1, "R12", busy, 1);
    @(negedge clk);
    chk(done == 0, "R12", done, 0);
    chk(busy == 0, "R12", busy, 0);
  endtask

  task automatic run_read(input logic [N-1:0] val, input int hold, input bit poke);
    int n = 0;
    int t0 = n_tx;
    logic [N-1:0] first;
    tag_mem = val;
    kick(2'b00);
    chk(fail == 0, "R11", fail, 0);
    if (poke) begin
      @(negedge clk); start = 1; op = 2'b01;
      @(negedge clk); start = 0;
    end
    while (!tag_valid && n < 20000) begin @(negedge clk); n++; end
    chk(tag_data == val, "R5", tag_data, val);
    chk(last_cmd == OPT, "R2", last_cmd, OPT);
    first = tag_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(tag_valid == 1 && done == 0 && tag_data == first, "R8", tag_data, first);
    end
    tag_ready = 1;
    @(negedge clk); tag_ready = 0;
    chk(done == 1, "R8", done, 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R12", done, 0);
    repeat (20) @(negedge clk);
    chk(n_tx - t0 == 1, "R3", n_tx - t0, 1);
  endtask

  task automatic run_poll(input int k);
    int t0 = n_tx;
    int exp_polls = (k < PMAX) ? k + 1 : PMAX;
    bit exp_fail = (k >= PMAX);
    ready_k = k; poll_idx = 0; wren_seen = 0;
    kick(2'b10);
    finish_job();
    chk(fail == exp_fail, "R11", fail, exp_fail);
    chk(poll_idx == exp_polls, "R11", poll_idx, exp_polls);
    chk(n_tx - t0 == exp_polls + 1, "R9", n_tx - t0, exp_polls + 1);
    repeat (20) @(negedge clk);
    chk(fail == exp_fail, "R11", fail, exp_fail);
  endtask

  initial begin
    int t0;
    void'($urandom(32'h5EED1));
    n_tx = 0; poll_idx = 0; ready_k = 0; tag_mem = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R1", {cs_n, sclk}, 2'b10);
    chk(busy == 0 && done == 0 && fail == 0 && tag_valid == 0, "R1",
        {busy, done, fail, tag_valid}, 0);

    t0 = n_tx;
    @(negedge clk); start = 1; op = 2'b11;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(busy == 0 && n_tx == t0, "R3", n_tx - t0, 0);

    run_read(32'h8000_0001, 0, 0);
    run_read(32'hFFFF_FFFF, 3, 1);
    for (int i = 0; i < 5; i++) run_read($urandom, $urandom % 4, 0);

    t0 = n_tx; wren_seen = 0;
    kick(2'b01);
    finish_job();
    chk(last_cmd == OPW && n_tx - t0 == 1, "R3", last_cmd, OPW);

    run_poll(0);
    run_poll(PMAX - 1);
    run_poll(PMAX);
    kick(2'b00);
    chk(fail == 0, "R11", fail, 0);
    tag_mem = 32'h0; tag_ready = 1;
    finish_job();
    tag_ready = 0;
    for (int i = 0; i < 3; i++) run_poll($urandom % (PMAX + 2));
    run_poll(2);
    summary();
  end
endmodule